// File: doc/BRIEF.md
# Host Bank Decoder

This block sits behind a host word bus and steers each access to one of four internal storage banks. The two top address bits pick the bank. The remaining bits form a window address inside that bank. The four banks are:

- a control bank: a handful of dedicated registers plus plain scratch words;
- a modulation sample bank;
- a single-pattern drive bank;
- a sequence bank.

The modulation and sequence banks are deeper than the window. Each has a page word in the control bank, and that page word is placed above the window bits to form the full address.

Every access, read or write, returns the word's prior contents on `rd_data` one clock later. The control bank also holds the following:

- Two fixed version words.
- An info word whose bit 0 mirrors an external thermal-sensor input.
- A mode word whose five flag bits are brought out as ports for the blocks that consume the stored data. The two page words are also brought out.

The full-size configuration uses a 16-bit bus (`ADDR_W=16`, 14-bit window) and depths of 2^11, 2^15, 2^9 and 2^19 words. The parameter defaults are a scaled build (10-bit bus, 8-bit window, depths 64/512/32/2048) with the same structure.

Top module: `host_bank_decoder`

## Requirements
- R1: `bus_addr[ADDR_W-1:ADDR_W-2]` selects the bank: 0 control, 1 modulation, 2 single pattern, 3 sequence. The lower `ADDR_W-2` bits are the window address, and each bank keeps its own independent contents.
- R2: An access presented with `bus_en` high at a rising edge sets `rd_data` after that edge. With no access, `rd_data` holds its value.
- R3: A write returns on `rd_data` the word's contents from before the write, and stores the new data for later accesses.
- R4: Modulation accesses use address `{mod_page, window}`, truncated to `MOD_AW` bits. `mod_page` is control word 4, is fully readable, and drives the `mod_page` port.
- R5: Sequence accesses use address `{seq_page, window}`, truncated to `SEQ_AW` bits. `seq_page` is control word 5, is fully readable, and drives the `seq_page` port.
- R6: Address bits above a bank's depth are ignored. Single-pattern and control accesses use only the low `SP_AW` and `CTRL_AW` window bits, and a page value too large for the bank wraps.
- R7: Control word 0 reads `{FEAT_BITS, VER_MAJOR}` (default 16'hA50B) and control word 1 reads `VER_MINOR` (default 16'h0003). Writes to them have no effect.
- R8: Control word 2 reads `{15'b0, thermal_in}`, with `thermal_in` taken at the access edge. Writes to it have no effect.
- R9: Control word 3 holds five mode bits, read back in bits [4:0] with the upper bits reading 0. The bits are: bit 0 `fan_force`, bit 1 `seq_enable`, bit 2 `seq_gain_sel`, bit 3 `seq_start_en`, bit 4 `seq_finish_en`. They change only on a write to word 3.
- R10: Control words 6 and above are plain storage.
- R11: During reset, `rd_data`, the mode outputs and both page outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Bank select and window address |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Prior contents of the last accessed word |
| thermal_in | input | 1 | Thermal-sensor level |
| fan_force | output | 1 | Mode bit 0 |
| seq_enable | output | 1 | Mode bit 1 |
| seq_gain_sel | output | 1 | Mode bit 2 |
| seq_start_en | output | 1 | Mode bit 3 |
| seq_finish_en | output | 1 | Mode bit 4 |
| mod_page | output | 16 | Modulation page word |
| seq_page | output | 16 | Sequence page word |

## Verification
Read data is due one edge after the access edge. Mode and page outputs change at the same edge that takes the write. The bench's reference model updates its expected values at each rising edge, from the inputs held there. It compares every output at the following falling edge, so each result is sampled exactly one register stage after its stimulus and never at the edge itself. Idle cycles between accesses check that `rd_data` holds.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef enum logic [1:0] {
        BK_CTRL   = 2'd0,
        BK_MOD    = 2'd1,
        BK_SINGLE = 2'd2,
        BK_SEQ    = 2'd3
    } bank_e;

    localparam int DATA_W     = 16;
    localparam int NUM_BANKS  = 4;
    localparam int MODE_W     = 5;

    // control bank word offsets
    localparam int OFF_VER     = 0;
    localparam int OFF_VER_MIN = 1;
    localparam int OFF_INFO    = 2;
    localparam int OFF_MODE    = 3;
    localparam int OFF_MODPG   = 4;
    localparam int OFF_SEQPG   = 5;

    // mode word bit positions
    localparam int MB_FAN    = 0;
    localparam int MB_SEQ    = 1;
    localparam int MB_GAIN   = 2;
    localparam int MB_START  = 3;
    localparam int MB_FINISH = 4;

endpackage

// File: rtl/hbd_decode.sv
module hbd_decode
    import hbd_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int CTRL_AW = 6,
    parameter int MOD_AW  = 9,
    parameter int SP_AW   = 5,
    parameter int SEQ_AW  = 11
) (
    input  logic                bus_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   mod_page,
    input  logic [DATA_W-1:0]   seq_page,
    output bank_e               bank,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic [CTRL_AW-1:0]  ctrl_a,
    output logic [MOD_AW-1:0]   mod_a,
    output logic [SP_AW-1:0]    sp_a,
    output logic [SEQ_AW-1:0]   seq_a
);
    localparam int WIN_W  = ADDR_W - 2;
    localparam int FULL_W = WIN_W + DATA_W;

    logic [WIN_W-1:0]  win;
    logic [1:0]        sel;
    logic [FULL_W-1:0] mod_full;
    logic [FULL_W-1:0] seq_full;
    logic              unused_hi_bits;

    assign sel  = bus_addr[ADDR_W-1 -: 2];
    assign win  = bus_addr[WIN_W-1:0];
    assign bank = bank_e'(sel);

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_en
            assign bank_en[b] = bus_en && (sel == 2'(b));
        end
    endgenerate

    // page word sits directly above the window; excess bits fall away
    assign mod_full = {mod_page, win};
    assign seq_full = {seq_page, win};

    assign ctrl_a = win[CTRL_AW-1:0];
    assign sp_a   = win[SP_AW-1:0];
    assign mod_a  = mod_full[MOD_AW-1:0];
    assign seq_a  = seq_full[SEQ_AW-1:0];

    assign unused_hi_bits = ^{mod_full, seq_full, win};

endmodule

// File: rtl/hbd_ram.sv
module hbd_ram
    import hbd_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 2 ** AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
    end

    // read captures the pre-write contents of the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= mem[addr];
        end
    end

endmodule

// File: rtl/hbd_ctrl_regs.sv
module hbd_ctrl_regs
    import hbd_pkg::*;
#(
    parameter int          CTRL_AW   = 6,
    parameter logic [7:0]  FEAT_BITS = 8'hA5,
    parameter logic [7:0]  VER_MAJOR = 8'h0B,
    parameter logic [15:0] VER_MINOR = 16'h0003
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc,
    input  logic               we,
    input  logic [CTRL_AW-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               thermal_in,
    output logic               hit_q,
    output logic [DATA_W-1:0]  q,
    output logic [MODE_W-1:0]  mode,
    output logic [DATA_W-1:0]  mod_page,
    output logic [DATA_W-1:0]  seq_page
);
    logic [DATA_W-1:0] rd_c;
    logic              hit_c;

    always_comb begin
        hit_c = 1'b1;
        case (addr)
            CTRL_AW'(OFF_VER):     rd_c = {FEAT_BITS, VER_MAJOR};
            CTRL_AW'(OFF_VER_MIN): rd_c = VER_MINOR;
            CTRL_AW'(OFF_INFO):    rd_c = {{(DATA_W-1){1'b0}}, thermal_in};
            CTRL_AW'(OFF_MODE):    rd_c = {{(DATA_W-MODE_W){1'b0}}, mode};
            CTRL_AW'(OFF_MODPG):   rd_c = mod_page;
            CTRL_AW'(OFF_SEQPG):   rd_c = seq_page;
            default: begin
                rd_c  = '0;
                hit_c = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= '0;
            mod_page <= '0;
            seq_page <= '0;
        end else if (acc && we) begin
            case (addr)
                CTRL_AW'(OFF_MODE):  mode     <= wdata[MODE_W-1:0];
                CTRL_AW'(OFF_MODPG): mod_page <= wdata;
                CTRL_AW'(OFF_SEQPG): seq_page <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            hit_q <= 1'b0;
        end else if (acc) begin
            q     <= rd_c;
            hit_q <= hit_c;
        end
    end

endmodule

// File: rtl/host_bank_decoder.sv
module host_bank_decoder
    import hbd_pkg::*;
#(
    parameter int          ADDR_W    = 10,
    parameter int          CTRL_AW   = 6,
    parameter int          MOD_AW    = 9,
    parameter int          SP_AW     = 5,
    parameter int          SEQ_AW    = 11,
    parameter logic [7:0]  FEAT_BITS = 8'hA5,
    parameter logic [7:0]  VER_MAJOR = 8'h0B,
    parameter logic [15:0] VER_MINOR = 16'h0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       rd_data,
    input  logic              thermal_in,
    output logic              fan_force,
    output logic              seq_enable,
    output logic              seq_gain_sel,
    output logic              seq_start_en,
    output logic              seq_finish_en,
    output logic [15:0]       mod_page,
    output logic [15:0]       seq_page
);
    bank_e                bank, bank_q;
    logic [NUM_BANKS-1:0] bank_en;
    logic [CTRL_AW-1:0]   ctrl_a;
    logic [MOD_AW-1:0]    mod_a;
    logic [SP_AW-1:0]     sp_a;
    logic [SEQ_AW-1:0]    seq_a;
    logic [DATA_W-1:0]    ctrl_q, mod_q, sp_q, seq_q, reg_q;
    logic                 reg_hit_q;
    logic [MODE_W-1:0]    mode;

    hbd_decode #(
        .ADDR_W (ADDR_W), .CTRL_AW(CTRL_AW), .MOD_AW(MOD_AW),
        .SP_AW  (SP_AW),  .SEQ_AW (SEQ_AW)
    ) u_dec (
        .bus_en  (bus_en),   .bus_addr(bus_addr),
        .mod_page(mod_page), .seq_page(seq_page),
        .bank    (bank),     .bank_en (bank_en),
        .ctrl_a  (ctrl_a),   .mod_a   (mod_a),
        .sp_a    (sp_a),     .seq_a   (seq_a)
    );

    hbd_ctrl_regs #(
        .CTRL_AW(CTRL_AW), .FEAT_BITS(FEAT_BITS),
        .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .acc(bank_en[BK_CTRL]), .we(bus_we),
        .addr(ctrl_a), .wdata(bus_wdata), .thermal_in(thermal_in),
        .hit_q(reg_hit_q), .q(reg_q), .mode(mode),
        .mod_page(mod_page), .seq_page(seq_page)
    );

    hbd_ram #(.AW(CTRL_AW)) u_ctrl_ram (
        .clk(clk), .rst_n(rst_n), .en(bank_en[BK_CTRL]), .we(bus_we),
        .addr(ctrl_a), .wdata(bus_wdata), .q(ctrl_q)
    );

    hbd_ram #(.AW(MOD_AW)) u_mod_ram (
        .clk(clk), .rst_n(rst_n), .en(bank_en[BK_MOD]), .we(bus_we),
        .addr(mod_a), .wdata(bus_wdata), .q(mod_q)
    );

    hbd_ram #(.AW(SP_AW)) u_sp_ram (
        .clk(clk), .rst_n(rst_n), .en(bank_en[BK_SINGLE]), .we(bus_we),
        .addr(sp_a), .wdata(bus_wdata), .q(sp_q)
    );

    hbd_ram #(.AW(SEQ_AW)) u_seq_ram (
        .clk(clk), .rst_n(rst_n), .en(bank_en[BK_SEQ]), .we(bus_we),
        .addr(seq_a), .wdata(bus_wdata), .q(seq_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= BK_CTRL;
        end else if (bus_en) begin
            bank_q <= bank;
        end
    end

    always_comb begin
        unique case (bank_q)
            BK_CTRL:   rd_data = reg_hit_q ? reg_q : ctrl_q;
            BK_MOD:    rd_data = mod_q;
            BK_SINGLE: rd_data = sp_q;
            BK_SEQ:    rd_data = seq_q;
        endcase
    end

    assign fan_force     = mode[MB_FAN];
    assign seq_enable    = mode[MB_SEQ];
    assign seq_gain_sel  = mode[MB_GAIN];
    assign seq_start_en  = mode[MB_START];
    assign seq_finish_en = mode[MB_FINISH];

endmodule

// File: rtl/hbd_checker.sv
module hbd_checker #(
    parameter int          ADDR_W    = 10,
    parameter int          CTRL_AW   = 6,
    parameter logic [7:0]  FEAT_BITS = 8'hA5,
    parameter logic [7:0]  VER_MAJOR = 8'h0B,
    parameter logic [15:0] VER_MINOR = 16'h0003
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       rd_data,
    input logic              thermal_in,
    input logic              fan_force,
    input logic              seq_enable,
    input logic              seq_gain_sel,
    input logic              seq_start_en,
    input logic              seq_finish_en,
    input logic [15:0]       mod_page,
    input logic [15:0]       seq_page
);
    logic               ctl_acc;
    logic [CTRL_AW-1:0] off;
    logic [4:0]         mode_o;

    assign ctl_acc = bus_en && (bus_addr[ADDR_W-1 -: 2] == 2'd0);
    assign off     = bus_addr[CTRL_AW-1:0];
    assign mode_o  = {seq_finish_en, seq_start_en, seq_gain_sel, seq_enable, fan_force};

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> $stable(rd_data));

    a_r7_version_major: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_acc && off == CTRL_AW'(0) |=> rd_data == {FEAT_BITS, VER_MAJOR});

    a_r7_version_minor: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_acc && off == CTRL_AW'(1) |=> rd_data == VER_MINOR);

    a_r8_info_word: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_acc && off == CTRL_AW'(2) |=> rd_data == {15'b0, $past(thermal_in)});

    a_r9_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_acc && bus_we && off == CTRL_AW'(3) |=> mode_o == $past(bus_wdata[4:0]));

    a_r9_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_acc && bus_we && off == CTRL_AW'(3)) |=> $stable(mode_o));

    a_r4_mod_page_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_acc && bus_we && off == CTRL_AW'(4) |=> mod_page == $past(bus_wdata));

    a_r5_seq_page_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_acc && bus_we && off == CTRL_AW'(5) |=> seq_page == $past(bus_wdata));

endmodule

bind host_bank_decoder hbd_checker #(
    .ADDR_W(ADDR_W), .CTRL_AW(CTRL_AW), .FEAT_BITS(FEAT_BITS),
    .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .thermal_in(thermal_in), .fan_force(fan_force), .seq_enable(seq_enable),
    .seq_gain_sel(seq_gain_sel), .seq_start_en(seq_start_en),
    .seq_finish_en(seq_finish_en), .mod_page(mod_page), .seq_page(seq_page)
);

// File: tb/host_bank_decoder_test.sv
module host_bank_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        thermal_in = 1'b0;
    logic [15:0] rd_data, mod_page, seq_page;
    logic        fan_force, seq_enable, seq_gain_sel, seq_start_en, seq_finish_en;

    host_bank_decoder uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .thermal_in(thermal_in), .fan_force(fan_force), .seq_enable(seq_enable),
        .seq_gain_sel(seq_gain_sel), .seq_start_en(seq_start_en),
        .seq_finish_en(seq_finish_en), .mod_page(mod_page), .seq_page(seq_page)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string tag = "R11";
    string exp_tag = "R11";

    // reference model state
    logic [15:0] m_ctrl [64];
    bit          k_ctrl [64];
    logic [15:0] m_mod  [512];
    bit          k_mod  [512];
    logic [15:0] m_sp   [32];
    bit          k_sp   [32];
    logic [15:0] m_seq  [2048];
    bit          k_seq  [2048];
    logic [4:0]  m_mode = '0;
    logic [15:0] m_pmod = '0;
    logic [15:0] m_pseq = '0;
    logic [15:0] exp_rd = '0;
    bit          exp_known = 1'b1;
    int          mb, mw, me;

    task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_rd = '0; exp_known = 1'b1; exp_tag = "R11";
            m_mode = '0; m_pmod = '0; m_pseq = '0;
        end else if (bus_en) begin
            exp_tag = tag;
            mb = int'(bus_addr[9:8]);
            mw = int'(bus_addr[7:0]);
            case (mb)
                0: begin
                    me = mw % 64;
                    exp_known = 1'b1;
                    case (me)
                        0: exp_rd = 16'hA50B;
                        1: exp_rd = 16'h0003;
                        2: exp_rd = {15'b0, thermal_in};
                        3: exp_rd = {11'b0, m_mode};
                        4: exp_rd = m_pmod;
                        5: exp_rd = m_pseq;
                        default: begin exp_rd = m_ctrl[me]; exp_known = k_ctrl[me]; end
                    endcase
                    if (bus_we) begin
                        case (me)
                            0, 1, 2: ;
                            3: m_mode = bus_wdata[4:0];
                            4: m_pmod = bus_wdata;
                            5: m_pseq = bus_wdata;
                            default: begin m_ctrl[me] = bus_wdata; k_ctrl[me] = 1'b1; end
                        endcase
                    end
                end
                1: begin
                    me = (int'(m_pmod) * 256 + mw) % 512;
                    exp_rd = m_mod[me]; exp_known = k_mod[me];
                    if (bus_we) begin m_mod[me] = bus_wdata; k_mod[me] = 1'b1; end
                end
                2: begin
                    me = mw % 32;
                    exp_rd = m_sp[me]; exp_known = k_sp[me];
                    if (bus_we) begin m_sp[me] = bus_wdata; k_sp[me] = 1'b1; end
                end
                default: begin
                    me = (int'(m_pseq) * 256 + mw) % 2048;
                    exp_rd = m_seq[me]; exp_known = k_seq[me];
                    if (bus_we) begin m_seq[me] = bus_wdata; k_seq[me] = 1'b1; end
                end
            endcase
        end else begin
            exp_tag = "R2";
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (exp_known) chk(exp_tag, rd_data, exp_rd);
            chk(rst_n ? "R9" : "R11",
                {11'b0, seq_finish_en, seq_start_en, seq_gain_sel, seq_enable, fan_force},
                {11'b0, m_mode});
            chk(rst_n ? "R4" : "R11", mod_page, m_pmod);
            chk(rst_n ? "R5" : "R11", seq_page, m_pseq);
        end
    end

    task automatic acc(input string r, input bit we, input int bank, input int win,
                       input logic [15:0] data);
        @(negedge clk);
        tag       = r;
        bus_en    = 1'b1;
        bus_we    = we;
        bus_addr  = {2'(bank), 8'(win)};
        bus_wdata = data;
        @(negedge clk);
        bus_en = 1'b0;
        bus_we = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++)   k_ctrl[i] = 1'b0;
        for (int i = 0; i < 512; i++)  k_mod[i]  = 1'b0;
        for (int i = 0; i < 32; i++)   k_sp[i]   = 1'b0;
        for (int i = 0; i < 2048; i++) k_seq[i]  = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11", rd_data, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: fixed version words, writes dropped
        acc("R7", 1'b0, 0, 0, 16'h0);
        acc("R7", 1'b0, 0, 1, 16'h0);
        acc("R7", 1'b1, 0, 0, 16'h1234);
        acc("R7", 1'b1, 0, 1, 16'h5678);
        acc("R7", 1'b0, 0, 0, 16'h0);
        acc("R7", 1'b0, 0, 1, 16'h0);

        // R8: thermal bit mirrored, writes dropped
        thermal_in = 1'b1;
        acc("R8", 1'b0, 0, 2, 16'h0);
        acc("R8", 1'b1, 0, 2, 16'hFFFE);
        thermal_in = 1'b0;
        acc("R8", 1'b0, 0, 2, 16'h0);

        // R9: mode word and its outputs
        acc("R9", 1'b1, 0, 3, 16'hFFFF);
        acc("R9", 1'b0, 0, 3, 16'h0);
        acc("R9", 1'b1, 0, 3, 16'h000A);
        acc("R9", 1'b0, 0, 3, 16'h0);

        // R1, R10: same window in every bank keeps separate contents
        acc("R10", 1'b1, 0, 10, 16'hC0C0);
        acc("R1", 1'b1, 1, 10, 16'h1111);
        acc("R1", 1'b1, 2, 10, 16'h2222);
        acc("R1", 1'b1, 3, 10, 16'h3333);
        acc("R10", 1'b0, 0, 10, 16'h0);
        acc("R1", 1'b0, 1, 10, 16'h0);
        acc("R1", 1'b0, 2, 10, 16'h0);
        acc("R1", 1'b0, 3, 10, 16'h0);

        // R3: a write returns the old word
        acc("R3", 1'b1, 2, 7, 16'hAAAA);
        acc("R3", 1'b1, 2, 7, 16'hBBBB);
        acc("R3", 1'b0, 2, 7, 16'h0);

        // R4: modulation paging, page 2 wraps onto page 0
        acc("R4", 1'b1, 1, 5, 16'h0A0A);
        acc("R4", 1'b1, 0, 4, 16'h0001);
        acc("R4", 1'b1, 1, 5, 16'h0B0B);
        acc("R4", 1'b0, 0, 4, 16'h0);
        acc("R4", 1'b1, 0, 4, 16'h0000);
        acc("R4", 1'b0, 1, 5, 16'h0);
        acc("R6", 1'b1, 0, 4, 16'h0002);
        acc("R6", 1'b0, 1, 5, 16'h0);

        // R5: sequence paging over all pages, page 8 wraps
        for (int p = 0; p < 8; p++) begin
            acc("R5", 1'b1, 0, 5, 16'(p));
            acc("R5", 1'b1, 3, 200, 16'h5000 + 16'(p));
        end
        for (int p = 0; p < 9; p++) begin
            acc("R5", 1'b1, 0, 5, 16'(p));
            acc("R5", 1'b0, 3, 200, 16'h0);
        end

        // R6: window bits above bank depth are ignored
        acc("R6", 1'b1, 2, 3, 16'h6363);
        acc("R6", 1'b0, 2, 35, 16'h0);
        acc("R6", 1'b1, 0, 70, 16'h7070);
        acc("R6", 1'b0, 0, 6, 16'h0);

        // R1, R2: back-to-back random traffic across all banks
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            tag       = "R1";
            bus_en    = ($urandom % 4) != 0;
            bus_we    = ($urandom % 2) != 0;
            bus_addr  = 10'($urandom);
            bus_wdata = 16'($urandom);
            thermal_in = ($urandom % 2) != 0;
        end
        @(negedge clk);
        bus_en = 1'b0;
        bus_we = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule